// File: doc/BRIEF.md
# Bit-Slice Arithmetic-Logic Unit

This block is a purely combinational 32-bit arithmetic-logic unit for a simple load/store processor datapath. It is built as a chain of identical one-bit cells. Each cell holds an AND gate, an OR gate, a full adder and a four-way output selector, and it can invert its own a and b inputs. The carry ripples from the least significant cell to the most significant one. Only the most significant cell carries the extra logic that derives the signed "less than" decision and the signed overflow indication.

A single 4-bit operation code steers the whole unit. Bit 3 inverts every a input. Bit 2 inverts every b input and also forces the carry into bit 0 to 1. Bits 1:0 choose each cell's output: 00 = AND, 01 = OR, 10 = adder sum, 11 = the cell's "less" input. Subtraction, NOR and set-on-less-than therefore reuse the same cells. For set-on-less-than, bit 0's "less" input is fed from the most significant cell's set value, and every other cell's "less" input is tied to 0. The outputs are valid once the carry chain has settled. There is no clock and no state.

Top module: `bsalu_top`

## Requirements
- R1: Code 4'b0000 yields result = opnd_a & opnd_b, bit by bit.
- R2: Code 4'b0001 yields result = opnd_a | opnd_b, bit by bit.
- R3: Code 4'b0010 yields result = (opnd_a + opnd_b) mod 2^32, and carry_out equals bit 32 of the unsigned sum.
- R4: Code 4'b0110 yields result = (opnd_a - opnd_b) mod 2^32, computed as a + ~b + 1. carry_out is 1 exactly when opnd_a >= opnd_b as unsigned numbers.
- R5: For codes 4'b0010 and 4'b0110, ovf_flag is 1 exactly when the two's-complement result does not fit in 32 bits. For add, that means the operands share a sign and the result's sign differs from it. For subtract, that means the operands' signs differ and the result's sign differs from a's.
- R6: Code 4'b0111 yields result = 1 when opnd_a < opnd_b as signed two's-complement numbers, and 0 otherwise. The decision is correct even when a - b overflows. Bits 31:1 are always 0.
- R7: Code 4'b1100 yields result = ~(opnd_a | opnd_b).
- R8: zero_flag is 1 exactly when all 32 result bits are 0, for every code.
- R9: Any code other than 0000, 0001, 0010, 0110, 0111 and 1100 yields result = 0, so zero_flag = 1. carry_out and ovf_flag are 0 for these codes.
- R10: carry_out and ovf_flag are 0 for every code other than 4'b0010 and 4'b0110, including 4'b0111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 4 | Bit 3 inverts a; bit 2 inverts b and sets the carry into bit 0; bits 1:0 choose the cell output |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | 1 when result is all zeros |
| carry_out | output | 1 | Carry from bit 31 for add and subtract, otherwise 0 |
| ovf_flag | output | 1 | Signed overflow for add and subtract, otherwise 0 |

## Verification
The bench aims at the points where a ripple-and-select design typically breaks.

- **Carry into bit 0.** Equal operands under subtract must give zero with carry set. A design that forgot to force the carry into bit 0 would be off by one.
- **Signed less-than under overflow.** The pairs 0x80000000 versus 1 and 0x7FFFFFFF versus -1 must give 1 and 0. A design that used only the raw sign bit would invert both answers.
- **Overflow boundaries.** 0x7FFFFFFF + 1 and 0x80000000 - 1 must raise ovf_flag, while all-ones plus one must only carry.
- **Unlisted codes and quiet flags.** Every code outside the six listed must give a zero result with quiet flags. A design without the legality gate would leak AND, OR or sum values there, and would report carry or overflow for set-on-less-than.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  // Operation codes: bit 3 inverts a, bit 2 inverts b and sets carry-in,
  // bits 1:0 pick the per-cell output.
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_LESS = 2'b11
  } pick_e;

  localparam int unsigned INV_A_BIT = 3;
  localparam int unsigned INV_B_BIT = 2;
  localparam int unsigned OP_W      = 4;

endpackage

// File: rtl/bsalu_decode.sv
module bsalu_decode
  import bsalu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output logic            inv_a,
  output logic            inv_b,
  output logic [1:0]      pick,
  output logic            legal,
  output logic            is_arith
);

  assign inv_a = op_code[INV_A_BIT];
  assign inv_b = op_code[INV_B_BIT];
  assign pick  = op_code[1:0];

  always_comb begin
    legal    = 1'b0;
    is_arith = 1'b0;
    case (op_code)
      OP_AND, OP_OR, OP_SLT, OP_NOR: legal = 1'b1;
      OP_ADD, OP_SUB: begin
        legal    = 1'b1;
        is_arith = 1'b1;
      end
      default: begin
        legal    = 1'b0;
        is_arith = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] pick_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);

  logic a_eff, b_eff, sum;

  assign a_eff  = a_i ^ inv_a_i;
  assign b_eff  = b_i ^ inv_b_i;
  assign sum    = a_eff ^ b_eff ^ cin_i;
  assign cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);

  always_comb begin
    case (pick_e'(pick_i))
      PICK_AND:  res_o = a_eff & b_eff;
      PICK_OR:   res_o = a_eff | b_eff;
      PICK_SUM:  res_o = sum;
      PICK_LESS: res_o = less_i;
      default:   res_o = 1'b0;
    endcase
  end

  // Only the top cell derives signed overflow and the less-than decision.
  generate
    if (IS_MSB) begin : g_msb
      assign ovf_o = cin_i ^ cout_o;
      assign set_o = sum ^ ovf_o;
    end else begin : g_plain
      assign ovf_o = 1'b0;
      assign set_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bsalu_zero_det.sv
module bsalu_zero_det #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);

  assign is_zero = ~(|value);

endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OP_W-1:0]  op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             carry_out,
  output logic             ovf_flag
);

  localparam int unsigned MSB = WIDTH - 1;

  logic             inv_a, inv_b, legal, is_arith;
  logic [1:0]       pick;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] slice_res, set_vec, ovf_vec;
  logic             set_raw, ovf_raw;

  bsalu_decode u_decode (
    .op_code  (op_code),
    .inv_a    (inv_a),
    .inv_b    (inv_b),
    .pick     (pick),
    .legal    (legal),
    .is_arith (is_arith)
  );

  // b inversion and carry-in share one control bit: a + ~b + 1.
  assign carry[0] = inv_b;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic less_w;
      if (i == 0) begin : g_lsb
        assign less_w = set_raw;
      end else begin : g_rest
        assign less_w = 1'b0;
      end
      bsalu_slice #(.IS_MSB(i == MSB)) u_slice (
        .a_i     (opnd_a[i]),
        .b_i     (opnd_b[i]),
        .inv_a_i (inv_a),
        .inv_b_i (inv_b),
        .cin_i   (carry[i]),
        .less_i  (less_w),
        .pick_i  (pick),
        .res_o   (slice_res[i]),
        .cout_o  (carry[i+1]),
        .set_o   (set_vec[i]),
        .ovf_o   (ovf_vec[i])
      );
    end
  endgenerate

  // Non-top cells drive constant zeros, so the reductions pick the top cell.
  assign set_raw = |set_vec;
  assign ovf_raw = |ovf_vec;

  assign result    = legal ? slice_res : '0;
  assign carry_out = is_arith & carry[WIDTH];
  assign ovf_flag  = is_arith & ovf_raw;

  bsalu_zero_det #(.WIDTH(WIDTH)) u_zero (
    .value   (result),
    .is_zero (zero_flag)
  );

  always_comb begin
    if (!$isunknown({op_code, opnd_a, opnd_b})) begin
      if (op_code == OP_ADD) begin
        p_add_sum_r3: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
          else $error("R3 ripple sum disagrees with arithmetic sum");
      end
      if (op_code == OP_SUB) begin
        p_sub_carry_r4: assert (carry_out == (opnd_a >= opnd_b))
          else $error("R4 subtract carry does not match unsigned compare");
      end
      if (op_code == OP_SLT) begin
        p_slt_bits_r6: assert (result[MSB:1] == '0 &&
                               result[0] == ($signed(opnd_a) < $signed(opnd_b)))
          else $error("R6 set-on-less-than result wrong");
      end
      if (!legal) begin
        p_unlisted_quiet_r9: assert (result == '0 && zero_flag && !carry_out && !ovf_flag)
          else $error("R9 unlisted code produced activity");
      end
      if (op_code != OP_ADD && op_code != OP_SUB) begin
        p_no_flags_r10: assert (!carry_out && !ovf_flag)
          else $error("R10 carry or overflow outside add/subtract");
      end
    end
  end

endmodule

// File: tb/bsalu_top_tb_top.sv
module bsalu_top_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [3:0]   op = 4'b0000;
  logic [W-1:0] result;
  logic         zero_flag, carry_out, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bsalu_top #(.WIDTH(W)) dut_i (
    .opnd_a    (a),
    .opnd_b    (b),
    .op_code   (op),
    .result    (result),
    .zero_flag (zero_flag),
    .carry_out (carry_out),
    .ovf_flag  (ovf_flag)
  );

  function automatic string tag_of(input logic [3:0] code);
    case (code)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R6";
      4'b1100: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Behavioural reference model from the requirements.
  task automatic model(input logic [W-1:0] ma, mb, input logic [3:0] mop,
                       output logic [W-1:0] r, output logic c, output logic v);
    logic [W:0] s;
    c = 1'b0; v = 1'b0; r = '0;
    case (mop)
      4'b0000: r = ma & mb;
      4'b0001: r = ma | mb;
      4'b0010: begin
        s = {1'b0, ma} + {1'b0, mb};
        r = s[W-1:0]; c = s[W];
        v = (ma[W-1] == mb[W-1]) && (r[W-1] != ma[W-1]);
      end
      4'b0110: begin
        r = ma - mb; c = (ma >= mb);
        v = (ma[W-1] != mb[W-1]) && (r[W-1] != ma[W-1]);
      end
      4'b0111: r = ($signed(ma) < $signed(mb)) ? 1 : 0;
      4'b1100: r = ~(ma | mb);
      default: r = '0;
    endcase
  endtask

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, tb, input logic [3:0] top);
    logic [W-1:0] er;
    logic ec, ev;
    string t;
    @(posedge clk);
    a <= ta; b <= tb; op <= top;
    @(negedge clk);
    model(ta, tb, top, er, ec, ev);
    t = tag_of(top);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result a=%h b=%h op=%b act=%h exp=%h", t, ta, tb, top, result, er);
    end
    check_bit("R8", "zero_flag", zero_flag, (er == '0));
    check_bit((top == 4'b0010 || top == 4'b0110) ? t : "R10", "carry_out", carry_out, ec);
    check_bit((top == 4'b0010 || top == 4'b0110) ? "R5" : "R10", "ovf_flag", ovf_flag, ev);
  endtask

  initial begin
    logic [3:0] ops [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // Reset state: zero operands, AND code.
    checks++;
    if (result !== '0 || zero_flag !== 1'b1) begin
      errors++;
      $display("FAIL R8 reset act=%h/%0b exp=0/1", result, zero_flag);
    end

    apply(32'hF0F0_1234, 32'hFF00_00FF, 4'b0000);   // R1
    apply(32'hF0F0_1234, 32'h0F00_00FF, 4'b0001);   // R2
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);   // R3 wrap, carry, zero
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);   // R5 positive overflow
    apply(32'h8000_0000, 32'h8000_0000, 4'b0010);   // R5 negative overflow
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);   // R4 equal: zero, carry 1
    apply(32'h0000_0000, 32'h0000_0001, 4'b0110);   // R4 borrow: carry 0
    apply(32'h8000_0000, 32'h0000_0001, 4'b0110);   // R5 subtract overflow
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);   // R6 overflow pair -> 1
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);   // R6 overflow pair -> 0
    apply(32'h0000_0005, 32'h0000_0005, 4'b0111);   // R6 equal -> 0, zero
    apply(32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'b0111);   // R6 negatives -> 1
    apply(32'h0000_0000, 32'h0000_0000, 4'b1100);   // R7 all ones
    apply(32'hFFFF_0000, 32'h0000_FF00, 4'b1100);   // R7

    // R9: every unlisted code with busy operands.
    for (int k = 0; k < 16; k++) begin
      if (k != 0 && k != 1 && k != 2 && k != 6 && k != 7 && k != 12)
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(k));
    end

    // Pseudo-random sweep over the six listed codes.
    for (int n = 0; n < 1200; n++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = (n % 7 == 0) ? ra : $urandom();
      if (n % 11 == 0) ra[W-1] = ~rb[W-1];
      apply(ra, rb, ops[n % 6]);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule